// File: doc/BRIEF.md
# Byte-Level I2C Master Command Front End

This block is the register-facing half of an I2C master. Software reaches it through a small word-indexed register port with eight registers: target address, control/status, data, timer period, interrupt mask, raw interrupt, masked interrupt and configuration. A write to the control register is decoded into a short series of byte-level bus commands: START with the address byte, SEND or RECV of one data byte, and STOP. These commands go to a separate bus agent that handles the SCL/SDA timing. The agent accepts each command with a valid/ready handshake and later returns one response that carries an acknowledge bit and, for a receive, the byte that was read.

The register port holds its acknowledge until the whole command series has completed, so a control write returns only after the bus work it asked for is done. The block keeps three flags: busy, error and arbitration-lost. It sets a one-bit transfer-done interrupt and drives the masked result on its interrupt pin. If a synchronous reset arrives while a transfer is open, the block closes the bus with a STOP before it accepts any register access.

Top module: `i2c_cmd_front`

## Requirements
- R1: Register indices on `reg_addr`: 0 target address, 1 control (write) / status (read), 2 data, 3 timer period, 4 interrupt mask, 5 raw interrupt, 6 masked interrupt (read only), 7 configuration. After reset every register reads 0, except the timer period, which reads 1, and status, which reads 0x20.
- R2: The configuration register keeps only the bits in mask 0x31. Bit 4 is the master enable.
- R3: While the master enable is clear, a control write is acknowledged in the same cycle, issues no command and changes no flag.
- R4: Control bit 1 (start) with busy clear issues START (`cmd_op`=0) with the target address register as `cmd_byte`. Bits 7:1 of that register are the address and bit 0 is the direction, where 1 means read. An acknowledged START sets busy (status bit 0) and clears arbitration-lost (status bit 2). A refused START sets arbitration-lost and leaves busy clear. Start with busy set issues nothing.
- R5: Control bit 0 (run) with busy clear or `line_busy` low sets error (status bit 1) and moves no data. Otherwise it clears error and issues one transfer: SEND (`cmd_op`=1) carrying the data register when the direction is 0, or RECV (`cmd_op`=2), whose returned byte is stored in the data register.
- R6: Every SEND or RECV that completes sets raw interrupt bit 0.
- R7: Control bit 2 (stop) issues STOP (`cmd_op`=3) and clears busy. Bits given together in one write run in the order start, transfer, stop.
- R8: `irq` equals raw bit 0 AND mask bit 0. Register 6 reads the same value. Writing register 5 with bit 0 set clears the raw bit. Writing it with bit 0 clear changes nothing.
- R9: A reset taken while busy is set is followed by exactly one STOP command, which completes before any register access is acknowledged.
- R10: An enabled control write is acknowledged only after its last command response. `cmd_valid`, `cmd_op` and `cmd_byte` stay stable until `cmd_ready`.
- R11: Status reads always return bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with `reg_ack` |
| reg_ack | output | 1 | Access completes at the next clock edge |
| cmd_valid | output | 1 | Bus command offered |
| cmd_ready | input | 1 | Agent takes the command |
| cmd_op | output | 2 | 0 START, 1 SEND, 2 RECV, 3 STOP |
| cmd_byte | output | 8 | Address byte for START, data byte for SEND |
| rsp_valid | input | 1 | Agent response strobe |
| rsp_ack | input | 1 | 1 = acknowledged, 0 = refused or arbitration lost |
| rsp_rdata | input | 8 | Byte received by a RECV |
| line_busy | input | 1 | Agent reports that the bus is held |
| irq | output | 1 | Transfer-done interrupt, masked |

## Verification
The control write is driven with each bit alone and with start+run, start+run+stop and run-only combinations. This separates the order in which commands are issued from the rules that decide whether each command is issued at all. Starts are sent to both a responding and a refusing agent, and while busy is already set, which tells the arbitration-lost path from the skipped-start path. Transfers are driven in both directions and with busy clear, so the bench can tell an error from a data move. A reset taken in the middle of an open transfer checks that the closing STOP comes before the first acknowledged access.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
    localparam int DATA_W = 8;
    localparam int REG_AW = 3;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [REG_AW-1:0] {
        RG_SADDR  = 3'd0,
        RG_CTRL   = 3'd1,
        RG_DATA   = 3'd2,
        RG_PERIOD = 3'd3,
        RG_IMASK  = 3'd4,
        RG_IRAW   = 3'd5,
        RG_IMST   = 3'd6,
        RG_CFG    = 3'd7
    } reg_idx_e;

    localparam int CB_RUN   = 0;
    localparam int CB_START = 1;
    localparam int CB_STOP  = 2;
    localparam int SB_IDLE  = 5;
    localparam int CFG_EN   = 4;
    localparam byte_t CFG_KEEP = 8'h31;

    typedef struct packed {
        logic arb;
        logic err;
        logic busy;
    } flags_t;

    typedef struct packed {
        logic busy_set;
        logic busy_clr;
        logic err_set;
        logic err_clr;
        logic arb_set;
        logic arb_clr;
        logic raw_set;
        logic data_load;
    } upd_t;

    function automatic byte_t status_word(flags_t f);
        byte_t w;
        w = '0;
        w[0] = f.busy;
        w[1] = f.err;
        w[2] = f.arb;
        w[SB_IDLE] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/i2cf_regs.sv
module i2cf_regs
    import i2cf_pkg::*;
#(
    parameter byte_t PERIOD_RST = 8'd1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_idx_e wr_idx,
    input  byte_t    wr_data,
    input  reg_idx_e rd_idx,
    input  upd_t     upd,
    input  byte_t    rx_byte,
    output byte_t    rd_data,
    output byte_t    saddr,
    output byte_t    data,
    output logic     cfg_en,
    output flags_t   flags,
    output logic     irq
);
    byte_t  sa_q, dat_q, per_q, cfg_q;
    logic   msk_q, raw_q;
    flags_t fl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sa_q  <= '0;
            dat_q <= '0;
            per_q <= PERIOD_RST;
            cfg_q <= '0;
            msk_q <= 1'b0;
            raw_q <= 1'b0;
            fl_q  <= '0;
        end else begin
            if (wr_en) begin
                case (wr_idx)
                    RG_SADDR:  sa_q  <= wr_data;
                    RG_DATA:   dat_q <= wr_data;
                    RG_PERIOD: per_q <= wr_data;
                    RG_IMASK:  msk_q <= wr_data[0];
                    RG_IRAW:   if (wr_data[0]) raw_q <= 1'b0;
                    RG_CFG:    cfg_q <= wr_data & CFG_KEEP;
                    default: ;
                endcase
            end
            if (upd.data_load) dat_q <= rx_byte;
            if (upd.raw_set)   raw_q <= 1'b1;
            if (upd.busy_set)      fl_q.busy <= 1'b1;
            else if (upd.busy_clr) fl_q.busy <= 1'b0;
            if (upd.err_set)       fl_q.err  <= 1'b1;
            else if (upd.err_clr)  fl_q.err  <= 1'b0;
            if (upd.arb_set)       fl_q.arb  <= 1'b1;
            else if (upd.arb_clr)  fl_q.arb  <= 1'b0;
        end
    end

    always_comb begin
        case (rd_idx)
            RG_SADDR:  rd_data = sa_q;
            RG_CTRL:   rd_data = status_word(fl_q);
            RG_DATA:   rd_data = dat_q;
            RG_PERIOD: rd_data = per_q;
            RG_IMASK:  rd_data = {{(DATA_W-1){1'b0}}, msk_q};
            RG_IRAW:   rd_data = {{(DATA_W-1){1'b0}}, raw_q};
            RG_IMST:   rd_data = {{(DATA_W-1){1'b0}}, raw_q & msk_q};
            RG_CFG:    rd_data = cfg_q;
            default:   rd_data = '0;
        endcase
    end

    assign saddr  = sa_q;
    assign data   = dat_q;
    assign cfg_en = cfg_q[CFG_EN];
    assign flags  = fl_q;
    assign irq    = raw_q & msk_q;
endmodule

// File: rtl/i2cf_seq.sv
module i2cf_seq
    import i2cf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    go,
    input  logic [2:0] go_bits,
    input  logic    busy_i,
    input  logic    line_busy,
    input  byte_t   saddr,
    input  byte_t   data,
    output logic    cmd_valid,
    input  logic    cmd_ready,
    output bus_op_e cmd_op,
    output byte_t   cmd_byte,
    input  logic    rsp_valid,
    input  logic    rsp_ack,
    output upd_t    upd,
    output logic    seq_idle,
    output logic    seq_done
);
    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_WAIT, S_RUNCHK, S_DONE
    } seq_state_e;

    seq_state_e st_q;
    bus_op_e    op_q;
    logic       run_q, stop_q, from_bus_q, rst_stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            op_q       <= OP_START;
            run_q      <= 1'b0;
            stop_q     <= 1'b0;
            from_bus_q <= 1'b0;
            rst_stop_q <= rst_stop_q | busy_i;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (rst_stop_q) begin
                        op_q       <= OP_STOP;
                        from_bus_q <= 1'b0;
                        st_q       <= S_REQ;
                    end else if (go) begin
                        run_q      <= go_bits[CB_RUN];
                        stop_q     <= go_bits[CB_STOP];
                        from_bus_q <= 1'b1;
                        if (go_bits[CB_START] && !busy_i) begin
                            op_q <= OP_START;
                            st_q <= S_REQ;
                        end else if (go_bits[CB_RUN]) begin
                            st_q <= S_RUNCHK;
                        end else if (go_bits[CB_STOP]) begin
                            op_q <= OP_STOP;
                            st_q <= S_REQ;
                        end else begin
                            st_q <= S_DONE;
                        end
                    end
                end
                S_REQ: if (cmd_ready) st_q <= S_WAIT;
                S_WAIT: if (rsp_valid) begin
                    case (op_q)
                        OP_START: begin
                            if (run_q) st_q <= S_RUNCHK;
                            else if (stop_q) begin
                                op_q <= OP_STOP;
                                st_q <= S_REQ;
                            end else st_q <= S_DONE;
                        end
                        OP_SEND, OP_RECV: begin
                            if (stop_q) begin
                                op_q <= OP_STOP;
                                st_q <= S_REQ;
                            end else st_q <= S_DONE;
                        end
                        default: begin
                            rst_stop_q <= 1'b0;
                            st_q <= from_bus_q ? S_DONE : S_IDLE;
                        end
                    endcase
                end
                S_RUNCHK: begin
                    if (!busy_i || !line_busy) begin
                        if (stop_q) begin
                            op_q <= OP_STOP;
                            st_q <= S_REQ;
                        end else st_q <= S_DONE;
                    end else begin
                        op_q <= saddr[0] ? OP_RECV : OP_SEND;
                        st_q <= S_REQ;
                    end
                end
                S_DONE: st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        upd = '0;
        if (st_q == S_WAIT && rsp_valid) begin
            case (op_q)
                OP_START: begin
                    if (rsp_ack) begin
                        upd.busy_set = 1'b1;
                        upd.arb_clr  = 1'b1;
                    end else begin
                        upd.arb_set  = 1'b1;
                    end
                end
                OP_SEND: upd.raw_set = 1'b1;
                OP_RECV: begin
                    upd.raw_set   = 1'b1;
                    upd.data_load = 1'b1;
                end
                default: upd.busy_clr = 1'b1;
            endcase
        end else if (st_q == S_RUNCHK) begin
            if (!busy_i || !line_busy) upd.err_set = 1'b1;
            else                       upd.err_clr = 1'b1;
        end
    end

    assign cmd_valid = (st_q == S_REQ);
    assign cmd_op    = op_q;
    assign cmd_byte  = (op_q == OP_START) ? saddr :
                       (op_q == OP_SEND)  ? data  : '0;
    assign seq_idle  = (st_q == S_IDLE) && !rst_stop_q;
    assign seq_done  = (st_q == S_DONE) && from_bus_q;
endmodule

// File: rtl/i2c_cmd_front.sv
module i2c_cmd_front
    import i2cf_pkg::*;
#(
    parameter byte_t PERIOD_RST = 8'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_ack,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [DATA_W-1:0] cmd_byte,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [DATA_W-1:0] rsp_rdata,
    input  logic              line_busy,
    output logic              irq
);
    reg_idx_e idx;
    upd_t     upd;
    flags_t   flags;
    byte_t    saddr, data;
    logic     cfg_en, seq_idle, seq_done, go, wr_en, is_ctrl;
    bus_op_e  op;

    assign idx     = reg_idx_e'(reg_addr);
    assign is_ctrl = (idx == RG_CTRL);
    assign go      = seq_idle && reg_req && reg_we && is_ctrl && cfg_en;
    assign wr_en   = seq_idle && reg_req && reg_we && !is_ctrl;
    assign reg_ack = (seq_idle && reg_req && !go) || (seq_done && reg_req);
    assign cmd_op  = op;

    i2cf_regs #(.PERIOD_RST(PERIOD_RST)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (reg_wdata),
        .rd_idx  (idx),
        .upd     (upd),
        .rx_byte (rsp_rdata),
        .rd_data (reg_rdata),
        .saddr   (saddr),
        .data    (data),
        .cfg_en  (cfg_en),
        .flags   (flags),
        .irq     (irq)
    );

    i2cf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .go_bits   (reg_wdata[2:0]),
        .busy_i    (flags.busy),
        .line_busy (line_busy),
        .saddr     (saddr),
        .data      (data),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (op),
        .cmd_byte  (cmd_byte),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack),
        .upd       (upd),
        .seq_idle  (seq_idle),
        .seq_done  (seq_done)
    );
endmodule

// File: rtl/i2cf_chk.sv
module i2cf_chk
    import i2cf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_req,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              reg_ack,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [DATA_W-1:0] cmd_byte,
    input logic              irq,
    input logic              cfg_en,
    input logic              seq_idle
);
    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

    // R10
    no_ack_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !reg_ack);

    // R11
    idle_bit_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_we && reg_addr == RG_CTRL && reg_ack |-> reg_rdata[SB_IDLE]);

    // R8
    raw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req && reg_we && reg_ack && reg_addr == RG_IRAW && reg_wdata[0] |=> !irq);

    // R3
    disabled_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        seq_idle && reg_req && reg_we && reg_addr == RG_CTRL && !cfg_en |-> reg_ack);

    // R3
    disabled_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        seq_idle && reg_req && reg_we && reg_addr == RG_CTRL && !cfg_en |=> !cmd_valid);
endmodule

bind i2c_cmd_front i2cf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_ack   (reg_ack),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .irq       (irq),
    .cfg_en    (cfg_en),
    .seq_idle  (seq_idle)
);

// File: tb/sim_i2c_cmd_front.sv
`timescale 1ns/1ps
module sim_i2c_cmd_front;
    logic       clk, rst;
    logic       reg_req, reg_we;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_ack;
    logic       cmd_valid, cmd_ready;
    logic [1:0] cmd_op;
    logic [7:0] cmd_byte;
    logic       rsp_valid, rsp_ack;
    logic [7:0] rsp_rdata;
    logic       line_busy;
    logic       irq;

    i2c_cmd_front u0 (.*);

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;
    bit chk_on = 0;

    // model state
    logic [7:0] m_sa, m_data, m_per, m_cfg;
    bit m_mask, m_raw, m_busy, m_err, m_arb, m_line;
    logic [7:0] ag_rdata = 8'h00;
    bit ag_ack = 1;
    logic [9:0] log_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sa = 0; m_data = 0; m_per = 1; m_cfg = 0;
        m_mask = 0; m_raw = 0; m_busy = 0; m_err = 0; m_arb = 0; m_line = 0;
    endtask

    function automatic logic [7:0] exp_reg(input int a);
        case (a)
            0: return m_sa;
            1: return 8'h20 | {5'b0, m_arb, m_err, m_busy};
            2: return m_data;
            3: return m_per;
            4: return {7'b0, m_mask};
            5: return {7'b0, m_raw};
            6: return {7'b0, m_raw & m_mask};
            default: return m_cfg;
        endcase
    endfunction

    task automatic model_wr(input int a, input logic [7:0] d);
        case (a)
            0: m_sa = d;
            2: m_data = d;
            3: m_per = d;
            4: m_mask = d[0];
            5: if (d[0]) m_raw = 0;
            7: m_cfg = d & 8'h31;
            default: ;
        endcase
    endtask

    task automatic bus_xfer(input bit we, input int a, input logic [7:0] d, output logic [7:0] q);
        chk_on = 0;
        @(negedge clk);
        reg_req = 1; reg_we = we; reg_addr = a[2:0]; reg_wdata = d;
        #0.1;
        while (!reg_ack) begin
            @(negedge clk);
            #0.1;
        end
        q = reg_rdata;
        @(posedge clk);
        #0.1;
        reg_req = 0; reg_we = 0;
        if (we) model_wr(a, d);
        chk_on = 1;
    endtask

    task automatic bus_wr(input int a, input logic [7:0] d);
        logic [7:0] q;
        bus_xfer(1, a, d, q);
    endtask

    task automatic rd_check(input int a, input string tag);
        logic [7:0] q;
        bus_xfer(0, a, 8'h00, q);
        check(q === exp_reg(a), tag, q, exp_reg(a));
    endtask

    // control write: predict ops and flags, then compare agent log
    task automatic ctrl_wr(input logic [7:0] v, input bit sack, input string tag);
        logic [9:0] exp_q[$];
        exp_q = {};
        log_q = {};
        ag_ack = sack;
        if (m_cfg[4]) begin
            if (v[1] && !m_busy) begin
                exp_q.push_back({2'd0, m_sa});
                if (sack) begin m_busy = 1; m_arb = 0; m_line = 1; end
                else m_arb = 1;
            end
            if (v[0]) begin
                if (!m_busy || !m_line) m_err = 1;
                else begin
                    m_err = 0;
                    if (m_sa[0]) begin
                        exp_q.push_back({2'd2, 8'h00});
                        m_data = ag_rdata;
                    end else exp_q.push_back({2'd1, m_data});
                    m_raw = 1;
                end
            end
            if (v[2]) begin
                exp_q.push_back({2'd3, 8'h00});
                m_busy = 0; m_line = 0;
            end
        end
        bus_wr(1, v);
        // R10: acknowledge only after the last response, so log is complete here
        check(log_q.size() == exp_q.size(), {tag, " R10 cmd count at ack"}, log_q.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < log_q.size())
                check(log_q[i] === exp_q[i], {tag, " command"}, log_q[i], exp_q[i]);
        repeat (2) @(negedge clk);
        rd_check(1, {tag, " status"});
    endtask

    // bus agent
    initial begin
        cmd_ready = 0; rsp_valid = 0; rsp_ack = 0; rsp_rdata = 0; line_busy = 0;
        forever begin
            logic [1:0] op;
            logic [7:0] b;
            @(negedge clk);
            if (cmd_valid && !rst) begin
                op = cmd_op; b = cmd_byte;
                cmd_ready = 1;
                @(negedge clk);
                cmd_ready = 0;
                log_q.push_back({op, b});
                @(negedge clk);
                rsp_valid = 1;
                rsp_ack = (op == 2'd0) ? ag_ack : 1'b1;
                rsp_rdata = ag_rdata;
                @(negedge clk);
                rsp_valid = 0;
                if (op == 2'd0 && ag_ack) line_busy = 1;
                if (op == 2'd3) line_busy = 0;
            end
        end
    end

    // R8: every-cycle interrupt comparison against the model
    always @(posedge clk) begin
        #1;
        if (chk_on && !rst && !done_flag) begin
            checks++;
            if (irq !== (m_raw & m_mask)) begin
                errors++;
                $display("FAIL R8 irq actual=%0b expected=%0b", irq, m_raw & m_mask);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset values
        for (int a = 0; a < 8; a++) rd_check(a, "R1 reset value");

        // R2 configuration keeps only 0x31
        bus_wr(7, 8'hFF);
        rd_check(7, "R2 cfg mask");
        bus_wr(7, 8'h00);

        // R3 control write ignored when disabled
        bus_wr(0, 8'hA0);
        log_q = {};
        ctrl_wr(8'h03, 1, "R3 disabled");
        check(cmd_valid === 1'b0, "R3 no command", cmd_valid, 0);

        // R4 R5 R6 start + send
        bus_wr(7, 8'h10);
        bus_wr(2, 8'h5A);
        ctrl_wr(8'h03, 1, "R4 R6 start+send");
        rd_check(5, "R6 raw set");
        rd_check(6, "R8 masked with mask 0");
        bus_wr(4, 8'h01);
        rd_check(6, "R8 masked with mask 1");
        check(irq === 1'b1, "R8 irq high", irq, 1);
        bus_wr(5, 8'h00);
        rd_check(5, "R8 clear with 0 keeps raw");
        bus_wr(5, 8'h01);
        check(irq === 1'b0, "R8 irq cleared", irq, 0);

        // R4 start while busy issues nothing
        ctrl_wr(8'h02, 1, "R4 start while busy");
        // R7 stop
        ctrl_wr(8'h04, 1, "R7 stop");

        // R5 run with busy clear -> error
        ctrl_wr(8'h01, 1, "R5 run not busy");
        // R5 read direction
        bus_wr(0, 8'hA1);
        ag_rdata = 8'hC3;
        ctrl_wr(8'h03, 1, "R5 start+recv");
        rd_check(2, "R5 received byte");
        ctrl_wr(8'h04, 1, "R7 stop after recv");

        // R4 refused start
        ctrl_wr(8'h03, 0, "R4 nack start");
        ctrl_wr(8'h02, 1, "R4 start clears arb");

        // R7 full sequence in one write, write direction
        ctrl_wr(8'h04, 1, "R7 close");
        bus_wr(0, 8'h42);
        bus_wr(2, 8'h99);
        ctrl_wr(8'h07, 1, "R7 start+send+stop");
        rd_check(6, "R6 raw after combined");

        // R9 reset while busy
        ctrl_wr(8'h02, 1, "R9 open");
        chk_on = 0;
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        log_q = {};
        model_reset();
        rst = 0;
        begin
            logic [7:0] q;
            bus_xfer(0, 1, 8'h00, q);
            check(log_q.size() == 1, "R9 stop before first access", log_q.size(), 1);
            if (log_q.size() > 0)
                check(log_q[0][9:8] == 2'd3, "R9 stop op", log_q[0][9:8], 3);
            check(q === 8'h20, "R9 status after reset", q, 8'h20);
        end
        repeat (3) @(negedge clk);
        rd_check(3, "R1 period after reset");
        rd_check(7, "R1 cfg after reset");

        repeat (3) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule